// File: doc/BRIEF.md
# Programmable Watchdog with Interrupt/Reset Steering

This block supervises a processor by counting down a programmed timeout and raising an alarm if software stops showing signs of life. Software loads an 8-bit configuration word. The word holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout equals the multiplier times the selected resolution. The count restarts on every write of the configuration word and on every edge, rising or falling, of an external kick line. The kick line is asynchronous and passes through a synchronizer first.

When the count runs out, a sticky watchdog flag is set. A read strobe from the flags register clears it. The steering bit then picks one of two responses:
- **Interrupt response.** A latched interrupt request is raised. Only a write of zero clears it, and that write also switches the watchdog off.
- **Reset response.** A fixed-length active-low reset pulse is emitted. The configuration word is wiped, and a one-cycle strobe tells neighbouring logic to clear its own control bits.

Time is counted from a one-cycle 16 Hz tick supplied from outside. A power-fail input wipes the configuration and disables the block.

Top module: `prog_watchdog`

## Requirements
- R1: The configuration word carries the steering bit in bit 7, the multiplier in bits 6..2 and the resolution code in bits 1..0. Resolution code 00 gives 1 tick, 01 gives 4 ticks, 10 gives 16 ticks and 11 gives 64 ticks of the 16 Hz input. The watchdog expires on the Nth tick after the last restart, where N is the multiplier times the resolution (0x0E gives 48 ticks).
- R2: A multiplier of zero disables the watchdog, so no expiry, flag, interrupt or reset pulse occurs however many ticks arrive.
- R3: A rising or a falling edge on `kick_i` restarts the countdown from the full timeout once it has passed the two-flop synchronizer.
- R4: A write of the configuration word restarts the countdown using the newly written value. A write has priority over a tick in the same cycle.
- R5: Expiry sets `wdf_o` in the next cycle. A `flags_rd_i` strobe clears it. If expiry and a read fall in the same cycle, the flag ends up set.
- R6: With steering bit 0, expiry sets `irq_o`. It stays set through nonzero writes and is cleared only by a write of 0x00, which also leaves the watchdog disabled.
- R7: With steering bit 1, expiry drives `rst_n_o` low for exactly `PULSE_CYCLES` clock cycles. It also pulses `ctl_clr_o` high for one cycle and clears the configuration word, which disables further expiry.
- R8: While `pwr_fail_i` is high, the configuration word is cleared, writes are ignored, `irq_o` is deasserted and the watchdog cannot expire.
- R9: After synchronous reset, `irq_o`=0, `rst_n_o`=1, `wdf_o`=0 and `ctl_clr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | One-cycle strobe at 16 Hz |
| wr_en_i | input | 1 | Configuration word write strobe |
| wr_data_i | input | 8 | Configuration word write data |
| flags_rd_i | input | 1 | Flags register read strobe |
| kick_i | input | 1 | Asynchronous kick line, both edges restart |
| pwr_fail_i | input | 1 | Power-fail indication, active high |
| irq_o | output | 1 | Latched watchdog interrupt request |
| rst_n_o | output | 1 | Active-low watchdog reset pulse |
| wdf_o | output | 1 | Sticky watchdog flag |
| ctl_clr_o | output | 1 | One-cycle strobe to clear companion control bits |

## Verification
A table of configuration words spans every resolution code and multipliers from 1 to 31. For each word the flag must stay clear after N−1 ticks and appear after the Nth tick, which separates a wrong step size or an off-by-one count from a correct one. Rising and falling kick edges, and a repeated write, are issued partway through a countdown, so a restart shows up as a full extra timeout rather than the leftover. Separate runs steer to the reset pulse and measure its width, compare a zero-multiplier word against a live one, and line up a flag read with an expiry in the same cycle to show that setting the flag wins.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MULT_W   = 5;
  localparam int STEP_LOG = 6;                 // largest step is 2**6 ticks
  localparam int CNT_W    = MULT_W + STEP_LOG; // holds 31*64

  typedef enum logic [1:0] {
    RES_TICK1  = 2'b00,
    RES_TICK4  = 2'b01,
    RES_TICK16 = 2'b10,
    RES_TICK64 = 2'b11
  } res_e;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    res_e              res;
  } wd_cfg_t;

  // timeout in 16 Hz ticks: multiplier shifted by twice the resolution code
  function automatic logic [CNT_W-1:0] timeout_ticks(wd_cfg_t c);
    return CNT_W'(c.mult) << {c.res, 1'b0};
  endfunction
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic edge_o
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], kick_i};
  end

  assign edge_o = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt;

  assign expire_o = enable_i && tick_i && !restart_i && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart_i) begin
      cnt <= load_i;
    end else if (enable_i && tick_i) begin
      if (cnt == CNT_W'(1))  cnt <= load_i;     // reload and keep running
      else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_CYCLES = 3277
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic pulse_n_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left      <= '0;
      pulse_n_o <= 1'b1;
    end else if (start_i) begin
      left      <= PW'(PULSE_CYCLES);
      pulse_n_o <= 1'b0;
    end else if (left > PW'(1)) begin
      left <= left - PW'(1);
    end else if (left == PW'(1)) begin
      left      <= '0;
      pulse_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/prog_watchdog.sv
module prog_watchdog
  import wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 3277,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       flags_rd_i,
  input  logic       kick_i,
  input  logic       pwr_fail_i,
  output logic       irq_o,
  output logic       rst_n_o,
  output logic       wdf_o,
  output logic       ctl_clr_o
);
  wd_cfg_t          cfg_q;
  wd_cfg_t          cfg_wr;
  logic             kick_edge;
  logic             wr_ok;
  logic             restart;
  logic             enable;
  logic             expire;
  logic [CNT_W-1:0] load_val;

  assign cfg_wr   = wd_cfg_t'(wr_data_i);
  assign wr_ok    = wr_en_i && !pwr_fail_i;
  assign restart  = wr_ok || kick_edge;
  assign enable   = (cfg_q.mult != '0) && !pwr_fail_i;
  assign load_val = wr_ok ? timeout_ticks(cfg_wr) : timeout_ticks(cfg_q);

  wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  wdt_countdown u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick16_i),
    .restart_i (restart),
    .enable_i  (enable),
    .load_i    (load_val),
    .expire_o  (expire)
  );

  wdt_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .start_i   (expire && cfg_q.steer),
    .pulse_n_o (rst_n_o)
  );

  // configuration word
  always_ff @(posedge clk) begin
    if (rst || pwr_fail_i)          cfg_q <= '0;
    else if (wr_ok)                 cfg_q <= cfg_wr;
    else if (expire && cfg_q.steer) cfg_q <= '0;
  end

  // registered status outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      wdf_o     <= 1'b0;
      ctl_clr_o <= 1'b0;
    end else begin
      ctl_clr_o <= expire && cfg_q.steer;

      if (expire)          wdf_o <= 1'b1;
      else if (flags_rd_i) wdf_o <= 1'b0;

      if (pwr_fail_i)                         irq_o <= 1'b0;
      else if (wr_en_i && wr_data_i == 8'h00) irq_o <= 1'b0;
      else if (expire && !cfg_q.steer)        irq_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int PULSE_CYCLES = 3277
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       flags_rd_i,
  input logic       pwr_fail_i,
  input logic       expire,
  input logic [7:0] cfg_q,
  input logic       irq_o,
  input logic       rst_n_o,
  input logic       wdf_o,
  input logic       ctl_clr_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk) begin
    if (rst)           low_cnt <= 0;
    else if (!rst_n_o) low_cnt <= low_cnt + 1;
    else               low_cnt <= 0;
  end

  a_r2_no_expire_when_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[6:2] == 5'd0) |-> !expire);

  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    expire |=> wdf_o);

  a_r5_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (flags_rd_i && !expire) |=> !wdf_o);

  a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !pwr_fail_i && !(wr_en_i && wr_data_i == 8'h00)) |=> irq_o);

  a_r6_zero_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i == 8'h00) |=> (!irq_o && cfg_q == 8'h00));

  a_r6_irq_on_expire: assert property (@(posedge clk) disable iff (rst)
    (expire && !cfg_q[7] && !pwr_fail_i) |=> irq_o);

  a_r7_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (expire && cfg_q[7]) |=> (!rst_n_o && ctl_clr_o && cfg_q == 8'h00));

  a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (low_cnt == PULSE_CYCLES));

  a_r8_power_fail: assert property (@(posedge clk) disable iff (rst)
    pwr_fail_i |=> (cfg_q == 8'h00 && !irq_o));
endmodule

bind prog_watchdog wdt_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .flags_rd_i (flags_rd_i),
  .pwr_fail_i (pwr_fail_i),
  .expire     (expire),
  .cfg_q      (cfg_q),
  .irq_o      (irq_o),
  .rst_n_o    (rst_n_o),
  .wdf_o      (wdf_o),
  .ctl_clr_o  (ctl_clr_o)
);

// File: tb/tb_prog_watchdog.sv
module tb_prog_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 12;
  localparam int NVEC       = 6;
  // {config word, ticks to expiry}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h04, 11'd1}, {8'h05, 11'd4}, {8'h0E, 11'd48},
    {8'h1A, 11'd96}, {8'h0B, 11'd128}, {8'h7F, 11'd1984}
  };

  logic clk = 0, rst = 1;
  logic tick = 0, wr = 0, frd = 0, kick = 0, pf = 0;
  logic [7:0] wdata = 0;
  logic irq, rst_n, wdf, cclr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_watchdog #(.PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst(rst), .tick16_i(tick), .wr_en_i(wr), .wr_data_i(wdata),
    .flags_rd_i(frd), .kick_i(kick), .pwr_fail_i(pf),
    .irq_o(irq), .rst_n_o(rst_n), .wdf_o(wdf), .ctl_clr_o(cclr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic write(logic [7:0] v);
    wdata = v; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic read_flags();
    frd = 1;
    @(negedge clk);
    frd = 0;
  endtask

  task automatic toggle_kick();
    kick = ~kick;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 irq", irq, 0);
    check("R9 rst_n", rst_n, 1);
    check("R9 wdf", wdf, 0);
    check("R9 ctl_clr", cclr, 0);

    // R1 table: flag must appear exactly on tick N
    for (int i = 0; i < NVEC; i++) begin
      write(VEC[i][18:11]);
      ticks(int'(VEC[i][10:0]) - 1);
      check("R1 no early expiry", wdf, 0);
      ticks(1);
      check("R1 expiry on tick N", wdf, 1);
      check("R6 irq on expiry", irq, 1);
      write(8'h00);
      check("R6 zero write clears irq", irq, 0);
      read_flags();
      check("R5 read clears flag", wdf, 0);
    end

    // R3 rising then falling kick edge restart
    write(8'h0E);
    ticks(40);
    toggle_kick();
    ticks(47);
    check("R3 rising kick restarts", wdf, 0);
    toggle_kick();
    ticks(47);
    check("R3 falling kick restarts", wdf, 0);
    ticks(1);
    check("R3 expiry after kick", wdf, 1);
    write(8'h00); read_flags();

    // R4 write restarts
    write(8'h05);
    ticks(3);
    write(8'h05);
    ticks(3);
    check("R4 rewrite restarts", wdf, 0);
    ticks(1);
    check("R4 expiry after rewrite", wdf, 1);

    // R6 nonzero write keeps irq, zero write disables
    write(8'h7C);
    check("R6 nonzero write keeps irq", irq, 1);
    write(8'h00);
    read_flags();
    ticks(200);
    check("R6 zero write disables", wdf, 0);
    check("R6 irq stays clear", irq, 0);

    // R5 set wins over simultaneous read
    write(8'h04);
    tick = 1; frd = 1;
    @(negedge clk);
    tick = 0; frd = 0;
    check("R5 set wins over read", wdf, 1);
    write(8'h00); read_flags();

    // R2 zero multiplier
    write(8'h83);
    ticks(200);
    check("R2 zero mult no flag", wdf, 0);
    check("R2 zero mult no reset", rst_n, 1);

    // R7 steering to reset pulse
    write(8'h84);
    ticks(1);
    check("R7 pulse low", rst_n, 0);
    check("R7 clear strobe", cclr, 1);
    check("R5 flag on reset expiry", wdf, 1);
    check("R7 no irq when steered", irq, 0);
    begin
      int low = 1;
      @(negedge clk);
      check("R7 strobe one cycle", cclr, 0);
      for (int k = 0; k < 4 * PULSE && rst_n == 0; k++) begin
        low++;
        @(negedge clk);
      end
      check("R7 pulse width", low, PULSE);
    end
    read_flags();
    ticks(20);
    check("R7 register cleared", wdf, 0);
    check("R7 pulse ends high", rst_n, 1);

    // R8 power fail
    write(8'h04);
    ticks(1);
    check("R8 irq before power fail", irq, 1);
    pf = 1;
    @(negedge clk);
    pf = 0;
    check("R8 power fail clears irq", irq, 0);
    read_flags();
    ticks(10);
    check("R8 disabled after power fail", wdf, 0);
    pf = 1;
    write(8'h04);
    ticks(3);
    pf = 0;
    ticks(10);
    check("R8 write ignored in power fail", wdf, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule